// File: doc/BRIEF.md
# Triple-Redundant Addressed Configuration Memory

This block holds a small set of global configuration words for a chip that must keep its settings through single-event upsets. A 5-bit address picks one of 32 words. Every bit of every word is held in three independent copies, so that one upset copy can be outvoted. A one-hot decoder turns the address into one line per word. With the write enable high, the addressed line loads the write data into all three copies at the next clock edge. With the write enable low, the same line gates that word onto the combinational read path.

The word width is a parameter from 1 to 16 bits. A second parameter picks what the read path returns: the bitwise two-of-three vote, or copy 0 alone. The second choice matches a build that has no voter. In both builds a mismatch flag shows when the three copies of the addressed word disagree. No logic ever rewrites a disagreeing copy. The only way to restore agreement is to write the word again. No net clears the array. To clear it, software writes zero to each address in turn. The reset input only qualifies the built-in checks and never touches the stored bits.

Top module: `tcm_config_mem`

## Requirements
- R1: When we_i is high at a rising clock edge, all three copies of the word at addr_i take the value of wdata_i. A later read of that address with we_i low returns that value and mismatch_o low.
- R2: A write changes only the addressed word. Every other word reads back unchanged. While we_i is low, no word changes at any clock edge.
- R3: While we_i is high, no word is on the read path: rdata_o is all zeros and mismatch_o is low.
- R4: Reading is combinational. With we_i low, a change of addr_i shows the newly addressed word on rdata_o in the same cycle, with no clock edge in between.
- R5: With OUT_SEL set to majority, each bit of rdata_o is the value that at least two of the three copies of the addressed word hold for that bit.
- R6: With we_i low, mismatch_o is high exactly when the three copies of the addressed word differ in at least one bit.
- R7: The block never repairs a copy by itself. Once the copies disagree, mismatch_o stays high on reads over many cycles until the word is written again. After that write, the copies agree.
- R8: Writing all-zero data to each of the 32 addresses clears the memory: every read then returns zero with mismatch_o low.
- R9: Asserting rst_i for any number of cycles leaves every stored word unchanged.
- R10: With OUT_SEL set to copy-0, rdata_o equals copy 0 of the addressed word, even when copies 1 and 2 hold another value. mismatch_o still reports any disagreement.
- R11: DATA_W sets the word width (1 to 16). A 4-bit build stores and returns 4-bit words with the same addressing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes take effect on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; qualifies the checks only, storage is kept |
| addr_i | input | ADDR_W (5) | Word address |
| we_i | input | 1 | High: load the addressed word; low: read it |
| wdata_i | input | DATA_W | Data written into all three copies |
| rdata_o | output | DATA_W | Combinational read data of the addressed word (voted or copy 0) |
| mismatch_o | output | 1 | High when the copies of the addressed word disagree (read only) |

## Verification
The hardest condition to reach is three copies that disagree. The block's own ports always write the same value into all three copies, so no sequence of port activity can ever produce a disagreement. To create one, the bench forces the packed storage vector of a single copy instance to its modelled content with chosen bits flipped, then releases it. The flipped value stays in place because storage only reloads on a write. From there the bench checks the vote, the copy-0 output, the mismatch flag over several idle cycles, and the recovery by a rewrite, all at the ports. Flips that hit two copies of the same bit are also covered, so the vote is shown to follow the majority even when the majority holds a wrong value.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    // Number of redundant copies of every stored bit.
    localparam int unsigned COPIES     = 3;
    // Widest word the array is built for.
    localparam int unsigned MAX_DATA_W = 16;

    // What the read path returns.
    typedef enum logic {
        OUT_MAJORITY = 1'b0,  // bitwise two-of-three vote
        OUT_COPY0    = 1'b1   // first copy only, no voter
    } out_sel_e;

    // Two-of-three vote on a single bit.
    function automatic logic vote_bit(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tcm_decoder.sv
module tcm_decoder #(
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned WORDS = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic [WORDS-1:0]  load_line_o,
    output logic [WORDS-1:0]  read_line_o
);

    logic [WORDS-1:0] line;

    // One select line per word.
    always_comb begin
        line = '0;
        line[addr_i] = 1'b1;
    end

    // Per-line strobes: load when writing, read gate otherwise.
    assign load_line_o = line & {WORDS{we_i}};
    assign read_line_o = line & {WORDS{~we_i}};

    // R1
    dec_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(load_line_o | read_line_o));

    // R2
    dec_noload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |-> (load_line_o == '0));

endmodule

// File: rtl/tcm_copy.sv
module tcm_copy #(
    parameter int unsigned WORDS  = 32,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BITS  = WORDS * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORDS-1:0]  load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [BITS-1:0]   bits_o
);

    // One redundant plane; deliberately without reset or clear.
    logic [BITS-1:0] bits_q;

    always_ff @(posedge clk_i) begin
        for (int w = 0; w < WORDS; w++) begin
            if (load_i[w]) begin
                bits_q[w*DATA_W +: DATA_W] <= data_i;
            end
        end
    end

    assign bits_o = bits_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_chk
        // R1
        cp_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            load_i[w] |=> (bits_q[w*DATA_W +: DATA_W] == $past(data_i)));
    end

endmodule

// File: rtl/tcm_voter.sv
module tcm_voter
    import tcm_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter out_sel_e    OUT_SEL = OUT_MAJORITY
) (
    input  logic [DATA_W-1:0] copy0_i,
    input  logic [DATA_W-1:0] copy1_i,
    input  logic [DATA_W-1:0] copy2_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mismatch_o
);

    if (OUT_SEL == OUT_MAJORITY) begin : g_vote
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign data_o[b] = vote_bit(copy0_i[b], copy1_i[b], copy2_i[b]);
        end
    end else begin : g_first
        assign data_o = copy0_i;
    end

    assign mismatch_o = |((copy0_i ^ copy1_i) | (copy0_i ^ copy2_i));

endmodule

// File: rtl/tcm_config_mem.sv
module tcm_config_mem
    import tcm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 16,
    parameter out_sel_e    OUT_SEL = OUT_MAJORITY,
    localparam int unsigned WORDS  = 1 << ADDR_W,
    localparam int unsigned BITS   = WORDS * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mismatch_o
);

    logic [WORDS-1:0]  load_line;
    logic [WORDS-1:0]  read_line;
    logic [BITS-1:0]   plane   [COPIES];
    logic [DATA_W-1:0] rd_word [COPIES];

    tcm_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .addr_i      (addr_i),
        .we_i        (we_i),
        .load_line_o (load_line),
        .read_line_o (read_line)
    );

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        tcm_copy #(.WORDS(WORDS), .DATA_W(DATA_W)) u_copy (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .load_i (load_line),
            .data_i (wdata_i),
            .bits_o (plane[c])
        );
    end

    // AND-OR read path gated by the per-line read strobes.
    always_comb begin
        for (int c = 0; c < COPIES; c++) begin
            rd_word[c] = '0;
            for (int w = 0; w < WORDS; w++) begin
                rd_word[c] |= {DATA_W{read_line[w]}} & plane[c][w*DATA_W +: DATA_W];
            end
        end
    end

    tcm_voter #(.DATA_W(DATA_W), .OUT_SEL(OUT_SEL)) u_vote (
        .copy0_i    (rd_word[0]),
        .copy1_i    (rd_word[1]),
        .copy2_i    (rd_word[2]),
        .data_o     (rdata_o),
        .mismatch_o (mismatch_o)
    );

    // R3
    wr_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |-> (rdata_o == '0) && !mismatch_o);

    // R5
    agree_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!we_i && !mismatch_o) |-> (rdata_o == rd_word[1]));

endmodule

// File: tb/tcm_config_mem_bench.sv
module tcm_config_mem_bench;
    import tcm_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  addr;
    logic        we;
    logic [15:0] wdata;
    logic [15:0] rdata16;
    logic        mm16;
    logic [3:0]  rdata4;
    logic        mm4;

    int checks = 0;
    int errors = 0;

    // Models of every copy of both instances.
    logic [15:0] m16 [3][32];
    logic [3:0]  m4  [3][32];

    always #5 clk = ~clk;

    tcm_config_mem #(.ADDR_W(5), .DATA_W(16), .OUT_SEL(OUT_MAJORITY)) u_tcm_config_mem (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata16), .mismatch_o(mm16)
    );

    tcm_config_mem #(.ADDR_W(5), .DATA_W(4), .OUT_SEL(OUT_COPY0)) u_tcm_config_mem_c0 (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .we_i(we),
        .wdata_i(wdata[3:0]), .rdata_o(rdata4), .mismatch_o(mm4)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one word; checks the quiet read path while we is high (R3).
    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        #1;
        check("R3 rdata during write", rdata16, 16'h0);
        check("R3 mismatch during write", {15'd0, mm16}, 16'h0);
        @(posedge clk);
        for (int c = 0; c < 3; c++) begin
            m16[c][a] = d;
            m4[c][a]  = d[3:0];
        end
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect_now(input string req, input logic [4:0] a);
        logic [15:0] x, y, z;
        logic [3:0]  p, q, r;
        x = m16[0][a]; y = m16[1][a]; z = m16[2][a];
        p = m4[0][a];  q = m4[1][a];  r = m4[2][a];
        check({req, " rdata"}, rdata16, (x & y) | (x & z) | (y & z));
        check({req, " mismatch"}, {15'd0, mm16}, {15'd0, (x != y) || (x != z)});
        check({req, " c0 rdata"}, {12'd0, rdata4}, {12'd0, p});
        check({req, " c0 mismatch"}, {15'd0, mm4}, {15'd0, (p != q) || (p != r)});
    endtask

    task automatic do_read(input string req, input logic [4:0] a);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        expect_now(req, a);
    endtask

    // Flip bits in one copy of the 16-bit instance by forcing its plane.
    task automatic inject16(input int c, input logic [4:0] a, input logic [15:0] mask);
        logic [511:0] vec;
        @(negedge clk);
        m16[c][a] = m16[c][a] ^ mask;
        for (int w = 0; w < 32; w++) vec[w*16 +: 16] = m16[c][w];
        case (c)
            0: begin force u_tcm_config_mem.g_copy[0].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem.g_copy[0].u_copy.bits_q; end
            1: begin force u_tcm_config_mem.g_copy[1].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem.g_copy[1].u_copy.bits_q; end
            default: begin force u_tcm_config_mem.g_copy[2].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem.g_copy[2].u_copy.bits_q; end
        endcase
    endtask

    task automatic inject4(input int c, input logic [4:0] a, input logic [3:0] mask);
        logic [127:0] vec;
        @(negedge clk);
        m4[c][a] = m4[c][a] ^ mask;
        for (int w = 0; w < 32; w++) vec[w*4 +: 4] = m4[c][w];
        case (c)
            0: begin force u_tcm_config_mem_c0.g_copy[0].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem_c0.g_copy[0].u_copy.bits_q; end
            1: begin force u_tcm_config_mem_c0.g_copy[1].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem_c0.g_copy[1].u_copy.bits_q; end
            default: begin force u_tcm_config_mem_c0.g_copy[2].u_copy.bits_q = vec; #1;
                     release u_tcm_config_mem_c0.g_copy[2].u_copy.bits_q; end
        endcase
    endtask

    // R8: clear by writing zeros everywhere
    task automatic t_clear();
        for (int a = 0; a < 32; a++) do_write(a[4:0], 16'h0000);
        for (int a = 0; a < 32; a++) begin
            do_read("R8", a[4:0]);
            check("R8 cleared word", rdata16, 16'h0000);
        end
    endtask

    // R1, R2, R11: distinct patterns, all words read back
    task automatic t_write_read();
        do_write(5'd0,  16'hA5C3);
        do_write(5'd31, 16'hFFFF);
        do_write(5'd7,  16'h1234);
        do_write(5'd8,  16'h8001);
        do_read("R1", 5'd7);
        check("R1 word 7", rdata16, 16'h1234);
        check("R11 narrow word 7", {12'd0, rdata4}, 16'h0004);
        do_read("R1", 5'd31);
        check("R1 word 31", rdata16, 16'hFFFF);
        for (int a = 0; a < 32; a++) do_read("R2", a[4:0]);
        do_write(5'd7, 16'h0F0F);
        do_read("R2", 5'd8);
        check("R2 neighbour kept", rdata16, 16'h8001);
        do_read("R1", 5'd7);
        check("R11 narrow overwrite", {12'd0, rdata4}, 16'h000F);
    endtask

    // R4: address change without a clock edge
    task automatic t_comb_read();
        @(negedge clk);
        we = 1'b0; addr = 5'd0;
        #1;
        check("R4 addr 0", rdata16, 16'hA5C3);
        addr = 5'd8;
        #1;
        check("R4 addr 8", rdata16, 16'h8001);
        addr = 5'd31;
        #1;
        check("R4 addr 31", rdata16, 16'hFFFF);
    endtask

    // R5, R6: single-copy and double-copy upsets
    task automatic t_vote();
        inject16(1, 5'd7, 16'h00F0);
        do_read("R5", 5'd7);
        check("R5 vote masks copy 1", rdata16, 16'h0F0F);
        check("R6 flag on copy 1 upset", {15'd0, mm16}, 16'h0001);
        do_read("R6", 5'd8);
        check("R6 clean word no flag", {15'd0, mm16}, 16'h0000);
        inject16(2, 5'd8, 16'h8000);
        inject16(0, 5'd8, 16'h8000);
        do_read("R5", 5'd8);
        check("R5 two copies win", rdata16, 16'h0001);
        inject16(0, 5'd31, 16'h0001);
        do_read("R5", 5'd31);
        check("R5 copy 0 outvoted", rdata16, 16'hFFFF);
    endtask

    // R7: no self-repair, rewrite restores agreement
    task automatic t_no_repair();
        for (int i = 0; i < 6; i++) begin
            do_read("R7", 5'd7);
            check("R7 flag persists", {15'd0, mm16}, 16'h0001);
        end
        do_write(5'd7, 16'h3C3C);
        do_read("R7", 5'd7);
        check("R7 flag gone after rewrite", {15'd0, mm16}, 16'h0000);
        check("R7 rewritten value", rdata16, 16'h3C3C);
    endtask

    // R10: copy-0 output build
    task automatic t_copy0();
        do_write(5'd12, 16'h0005);
        inject4(1, 5'd12, 4'hF);
        inject4(2, 5'd12, 4'hF);
        do_read("R10", 5'd12);
        check("R10 copy0 despite majority", {12'd0, rdata4}, 16'h0005);
        check("R10 flag", {15'd0, mm4}, 16'h0001);
        inject4(0, 5'd12, 4'h1);
        do_read("R10", 5'd12);
        check("R10 follows copy0 upset", {12'd0, rdata4}, 16'h0004);
    endtask

    // R9: reset keeps content
    task automatic t_reset_keeps();
        do_write(5'd20, 16'hBEEF);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_read("R9", 5'd20);
        check("R9 word after reset", rdata16, 16'hBEEF);
        do_read("R9", 5'd0);
        check("R9 other word after reset", rdata16, 16'hA5C3);
    endtask

    initial begin
        rst = 1'b1; addr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_clear();
        t_write_read();
        t_comb_read();
        t_vote();
        t_no_repair();
        t_copy0();
        t_reset_keeps();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule